// File: doc/BRIEF.md
# Triggered Time Base with Event Postscaler

This block is a 16-bit up-counter that returns to zero after it reaches a programmable period value. It can run freely, or in trigger mode wait at zero until a rising edge arrives on one line picked from a vector of up to 32 source signals. A triggered run can be bounded to a small number of full periods (one-shot), and can optionally be restarted by a fresh trigger while it is still counting.

A 4-bit postscaler thins a stream of events into a single-cycle interrupt pulse. The stream is either the period-match pulses or the accepted-trigger pulses. In capture operation it is an externally supplied capture event instead. A synchronisation output carries either the rollover pulse or an alternate input signal.

Top module: `trig_timer`

## Requirements
- R1: While `enable` is low the counter is forced to zero, `running` is low, and `irq` is low from the next clock on. After a synchronous `rst` the counter and `irq` are zero.
- R2: With `trig_en` low and `enable` high the counter advances by one per clock. `match` is high in the cycle where `count` equals `period`. The counter is zero on the following clock, so one period lasts `period`+1 clocks.
- R3: With `trig_en` high the counter holds and `running` stays low until a rising edge appears on `src_vec[trig_sel]`. `trig_out` pulses in the cycle the edge is seen. On the next clock `running` is high with `count` at zero, and counting starts after that.
- R4: Triggers are edges, so a source held high starts nothing further. A rising edge while running with `retrig_en` low is ignored and gives no `trig_out`.
- R5: With `trig_en` and `retrig_en` high, a rising edge while running pulses `trig_out` and the counter is zero on the next clock. This restart takes priority over a period match in the same cycle.
- R6: With `trig_en` and `one_shot` high, a triggered run lasts `shot_len`+1 full periods. After the last match `running` goes low and `count` is zero.
- R7: With `trig_en` low, `retrig_en` and edges on the selected source have no effect on the count sequence.
- R8: The postscaler pulses `irq` for one clock, one clock after every (`ps_sel`+1)th counted event. For example, `ps_sel`=0 gives one pulse per event and `ps_sel`=15 gives one per 16.
- R9: With `capture_mode` low, `ps_src`=0 counts `match` pulses and `ps_src`=1 counts `trig_out` pulses.
- R10: With `capture_mode` high the postscaler counts `capture_evt` pulses and `ps_src` has no effect. With `capture_mode` low, `capture_evt` is ignored.
- R11: The postscaler's event count restarts from zero whenever `ps_sel`, `ps_src` or `capture_mode` differs from its value on the previous clock, or while `enable` is low. An event in such a cycle is dropped.
- R12: `sync_out` equals `match` when `alt_sync` is 0 and equals `alt_in` when `alt_sync` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable |
| trig_en | input | 1 | Wait for a trigger before counting |
| one_shot | input | 1 | Bound each triggered run |
| retrig_en | input | 1 | Allow a trigger to restart a running count |
| shot_len | input | 3 | Extra periods in a one-shot run |
| ps_src | input | 1 | Postscaler source: 0 match, 1 accepted trigger |
| capture_mode | input | 1 | Postscaler counts capture events |
| capture_evt | input | 1 | Capture event pulse |
| ps_sel | input | 4 | Postscale ratio minus one |
| alt_sync | input | 1 | Sync output carries `alt_in` |
| alt_in | input | 1 | Alternate synchronisation signal |
| trig_sel | input | 5 | Index of the trigger source |
| src_vec | input | 32 | Trigger source lines |
| period | input | 16 | Terminal count value |
| count | output | 16 | Current count |
| running | output | 1 | Time base is counting |
| match | output | 1 | Count equals period while running |
| trig_out | output | 1 | Trigger accepted this cycle |
| sync_out | output | 1 | Synchronisation output |
| irq | output | 1 | Postscaled interrupt pulse |

## Verification
The hardest state to reach is the end of a one-shot run. A trigger edge ignored mid-run must leave the period tally untouched, and the final match must drop `running` rather than wrap into another period. A cycle-by-cycle vector table reaches it by driving the selected source through a rise, a held-high level, a rise during the run, and a rise after the run. Every row checks count, running, trigger acceptance and match. The postscaler clear is reached separately: one capture event leaves a partial tally, and a one-cycle change of the ratio field must then cancel it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        TB_HOLD = 1'b0,
        TB_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic trig_en;
        logic one_shot;
        logic retrig_en;
    } trig_mode_t;

    typedef struct packed {
        logic cap_mode;
        logic src_trig;
    } ps_route_t;

    // choose which pulse stream feeds the postscaler
    function automatic logic pick_ps_event(input ps_route_t r, input logic mtch,
                                           input logic trig, input logic cap);
        if (r.cap_mode)
            return cap;
        return r.src_trig ? trig : mtch;
    endfunction

endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel #(
    parameter int NSRC  = 32,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_vec,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);
    logic cur;
    logic prev_q;

    assign cur  = src_vec[sel];
    assign rise = cur & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= cur;
    end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SHOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  trig_mode_t        mode,
    input  logic [CNT_W-1:0]  period,
    input  logic [SHOT_W-1:0] shot_len,
    input  logic              trig_rise,
    output logic [CNT_W-1:0]  count,
    output logic              active,
    output logic              match,
    output logic              accept
);
    run_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SHOT_W-1:0] shot_q;
    logic              last_shot;

    assign active    = enable & (mode.trig_en ? (st_q == TB_RUN) : 1'b1);
    assign match     = active & (cnt_q == period);
    assign accept    = enable & mode.trig_en & trig_rise
                     & ((st_q == TB_HOLD) | mode.retrig_en);
    assign last_shot = (shot_q == shot_len);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q  <= '0;
            st_q   <= TB_HOLD;
            shot_q <= '0;
        end else if (!mode.trig_en) begin
            st_q   <= TB_HOLD;
            shot_q <= '0;
            cnt_q  <= match ? '0 : cnt_q + 1'b1;
        end else if (accept) begin
            cnt_q  <= '0;
            st_q   <= TB_RUN;
            shot_q <= '0;
        end else if (st_q == TB_RUN) begin
            if (match) begin
                cnt_q <= '0;
                if (mode.one_shot) begin
                    if (last_shot) begin
                        st_q   <= TB_HOLD;
                        shot_q <= '0;
                    end else begin
                        shot_q <= shot_q + 1'b1;
                    end
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_postscale.sv
module tmr_postscale
    import tmr_pkg::*;
#(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic [PS_W-1:0] ps_sel,
    input  ps_route_t       route,
    input  logic            evt,
    output logic            irq
);
    logic [PS_W-1:0] sel_q;
    ps_route_t       route_q;
    logic [PS_W-1:0] tally_q;
    logic            irq_q;
    logic            cfg_moved;

    assign cfg_moved = (ps_sel != sel_q) || (route != route_q);
    assign irq       = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            route_q <= '0;
            tally_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            sel_q   <= ps_sel;
            route_q <= route;
            if (!enable || cfg_moved) begin
                tally_q <= '0;
                irq_q   <= 1'b0;
            end else if (evt) begin
                if (tally_q == ps_sel) begin
                    tally_q <= '0;
                    irq_q   <= 1'b1;
                end else begin
                    tally_q <= tally_q + 1'b1;
                    irq_q   <= 1'b0;
                end
            end else begin
                irq_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import tmr_pkg::*;
#(
    parameter int  CNT_W  = 16,
    parameter int  PS_W   = 4,
    parameter int  SHOT_W = 3,
    parameter int  NSRC   = 32,
    localparam int SEL_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              trig_en,
    input  logic              one_shot,
    input  logic              retrig_en,
    input  logic [SHOT_W-1:0] shot_len,
    input  logic              ps_src,
    input  logic              capture_mode,
    input  logic              capture_evt,
    input  logic [PS_W-1:0]   ps_sel,
    input  logic              alt_sync,
    input  logic              alt_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [NSRC-1:0]   src_vec,
    input  logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              match,
    output logic              trig_out,
    output logic              sync_out,
    output logic              irq
);
    trig_mode_t mode;
    ps_route_t  route;
    logic       trig_rise;
    logic       ps_evt;

    assign mode  = '{trig_en: trig_en, one_shot: one_shot, retrig_en: retrig_en};
    assign route = '{cap_mode: capture_mode, src_trig: ps_src};

    tmr_edge_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .src_vec (src_vec),
        .sel     (trig_sel),
        .rise    (trig_rise)
    );

    tmr_timebase #(.CNT_W(CNT_W), .SHOT_W(SHOT_W)) u_base (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .mode      (mode),
        .period    (period),
        .shot_len  (shot_len),
        .trig_rise (trig_rise),
        .count     (count),
        .active    (running),
        .match     (match),
        .accept    (trig_out)
    );

    assign ps_evt = pick_ps_event(route, match, trig_out, capture_evt);

    tmr_postscale #(.PS_W(PS_W)) u_ps (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .ps_sel (ps_sel),
        .route  (route),
        .evt    (ps_evt),
        .irq    (irq)
    );

    assign sync_out = alt_sync ? alt_in : match;
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             trig_en,
    input logic             ps_src,
    input logic             capture_mode,
    input logic             capture_evt,
    input logic             alt_sync,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             match,
    input logic             trig_out,
    input logic             sync_out,
    input logic             irq
);
    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count == '0 && !irq)); // R1

    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (rst)
        match |=> (count == '0)); // R2

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && trig_en && !running && !trig_out) |=> $stable(count)); // R3

    AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
        (trig_en && enable && $past(trig_en) && $past(enable) && $rose(running))
        |-> $past(trig_out)); // R3

    AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(capture_mode ? capture_evt : (ps_src ? trig_out : match))); // R9

    AST_SYNC_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        (!alt_sync && sync_out) |=> (count == '0)); // R12
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .trig_en      (trig_en),
    .ps_src       (ps_src),
    .capture_mode (capture_mode),
    .capture_evt  (capture_evt),
    .alt_sync     (alt_sync),
    .count        (count),
    .running      (running),
    .match        (match),
    .trig_out     (trig_out),
    .sync_out     (sync_out),
    .irq          (irq)
);

// File: tb/test_trig_timer.sv
module test_trig_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable, trig_en, one_shot, retrig_en;
    logic [2:0]  shot_len;
    logic        ps_src, capture_mode, capture_evt;
    logic [3:0]  ps_sel;
    logic        alt_sync, alt_in;
    logic [4:0]  trig_sel;
    logic [31:0] src_vec;
    logic [15:0] period;
    logic [15:0] count;
    logic        running, match, trig_out, sync_out, irq;

    int total = 0;
    int bad   = 0;
    int irq_seen = 0;
    int irq_adjacent = 0;
    logic irq_last = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_timer i_trig_timer (
        .clk(clk), .rst(rst), .enable(enable), .trig_en(trig_en),
        .one_shot(one_shot), .retrig_en(retrig_en), .shot_len(shot_len),
        .ps_src(ps_src), .capture_mode(capture_mode), .capture_evt(capture_evt),
        .ps_sel(ps_sel), .alt_sync(alt_sync), .alt_in(alt_in),
        .trig_sel(trig_sel), .src_vec(src_vec), .period(period),
        .count(count), .running(running), .match(match), .trig_out(trig_out),
        .sync_out(sync_out), .irq(irq)
    );

    // one-shot trigger table: {src, count[2:0], running, trig_out, match}
    localparam int NVEC = 11;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_000_000, 7'b1_000_010, 7'b1_000_100, 7'b0_001_100,
        7'b0_010_101, 7'b1_000_100, 7'b0_001_100, 7'b0_010_101,
        7'b0_000_000, 7'b1_000_010, 7'b0_000_100
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (irq) irq_seen++;
        if (irq && irq_last) irq_adjacent++;
        irq_last = irq;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic disable_cycle();
        enable = 1'b0;
        tick();
        tick();
        irq_seen = 0;
        irq_adjacent = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b1; trig_en = 1'b0; one_shot = 1'b0;
        retrig_en = 1'b0; shot_len = 3'd0; ps_src = 1'b0; capture_mode = 1'b0;
        capture_evt = 1'b0; ps_sel = 4'd0; alt_sync = 1'b0; alt_in = 1'b0;
        trig_sel = 5'd0; src_vec = '0; period = 16'd3;

        // R1: reset state
        tick(); tick();
        chk("R1 reset count", int'(count), 0);
        chk("R1 reset irq", int'(irq), 0);
        rst = 1'b0;

        // R1: disabling clears
        tick(); tick();
        enable = 1'b0;
        settle();
        chk("R1 running low while disabled", int'(running), 0);
        tick();
        chk("R1 count zero after disable", int'(count), 0);
        chk("R1 irq low after disable", int'(irq), 0);

        // R2, R7, R12: free run, period 3, edges on source ignored
        trig_sel = 5'd5; retrig_en = 1'b1;
        enable = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (i > 0) tick();
            if (i == 4) src_vec[5] = 1'b1;
            if (i == 6) src_vec[5] = 1'b0;
            settle();
            chk("R2 R7 free-run count", int'(count), i % 4);
            chk("R2 match at period", int'(match), int'(i % 4 == 3));
            chk("R12 sync follows match", int'(sync_out), int'(match));
        end
        // R12: alternate signal routed
        alt_sync = 1'b1; alt_in = 1'b1; settle();
        chk("R12 alt high", int'(sync_out), 1);
        alt_in = 1'b0; settle();
        chk("R12 alt low", int'(sync_out), 0);
        alt_sync = 1'b0; retrig_en = 1'b0;

        // R3, R4, R6: one-shot table walk
        disable_cycle();
        trig_en = 1'b1; one_shot = 1'b1; shot_len = 3'd1; period = 16'd2;
        trig_sel = 5'd0; src_vec = '0;
        tick();
        enable = 1'b1;
        for (int r = 0; r < NVEC; r++) begin
            tick();
            src_vec[0] = VEC[r][6];
            settle();
            chk($sformatf("R3 R4 R6 row%0d count", r), int'(count), int'(VEC[r][5:3]));
            chk($sformatf("R3 R6 row%0d running", r), int'(running), int'(VEC[r][2]));
            chk($sformatf("R3 R4 row%0d trig_out", r), int'(trig_out), int'(VEC[r][1]));
            chk($sformatf("R6 row%0d match", r), int'(match), int'(VEC[r][0]));
        end

        // R5: retrigger restarts a running count
        disable_cycle();
        src_vec = '0; trig_sel = 5'd5; one_shot = 1'b0; retrig_en = 1'b1; period = 16'd20;
        enable = 1'b1;
        tick();
        src_vec[5] = 1'b1; settle();
        chk("R5 first trigger accepted", int'(trig_out), 1);
        tick();
        src_vec[5] = 1'b0; settle();
        chk("R5 running after trigger", int'(running), 1);
        tick(); tick(); tick();
        chk("R5 count before retrigger", int'(count), 3);
        src_vec[5] = 1'b1; settle();
        chk("R5 retrigger accepted", int'(trig_out), 1);
        tick();
        src_vec[5] = 1'b0; settle();
        chk("R5 count restarted", int'(count), 0);
        chk("R5 still running", int'(running), 1);

        // R8, R9: postscale 1:3 on match events, period 1
        src_vec = '0; retrig_en = 1'b0;
        trig_en = 1'b0; period = 16'd1; ps_sel = 4'd2; ps_src = 1'b0;
        disable_cycle();
        enable = 1'b1;
        for (int j = 0; j < 25; j++) tick();
        chk("R8 R9 irq per third match", irq_seen, 4);
        chk("R8 irq single cycle", irq_adjacent, 0);

        // R9: postscaler on accepted triggers, ratio 1:2
        trig_en = 1'b1; retrig_en = 1'b1; period = 16'd200; ps_sel = 4'd1; ps_src = 1'b1;
        disable_cycle();
        enable = 1'b1;
        for (int j = 0; j < 4; j++) begin
            tick(); src_vec[5] = 1'b1;
            tick(); src_vec[5] = 1'b0;
        end
        tick(); tick(); tick();
        chk("R9 irq per second trigger", irq_seen, 2);
        ps_src = 1'b0;
        disable_cycle();
        enable = 1'b1;
        for (int j = 0; j < 4; j++) begin
            tick(); src_vec[5] = 1'b1;
            tick(); src_vec[5] = 1'b0;
        end
        tick(); tick(); tick();
        chk("R9 triggers not counted on match source", irq_seen, 0);

        // R10: capture mode counts capture events only
        retrig_en = 1'b0; capture_mode = 1'b1; ps_src = 1'b1; ps_sel = 4'd0;
        disable_cycle();
        enable = 1'b1;
        tick(); src_vec[5] = 1'b1;
        tick(); src_vec[5] = 1'b0;
        tick(); tick();
        chk("R10 trigger ignored in capture mode", irq_seen, 0);
        for (int j = 0; j < 3; j++) begin
            tick(); capture_evt = 1'b1;
            tick(); capture_evt = 1'b0;
        end
        tick(); tick();
        chk("R10 irq per capture event", irq_seen, 3);
        capture_mode = 1'b0; ps_src = 1'b0;
        disable_cycle();
        enable = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick(); capture_evt = 1'b1;
            tick(); capture_evt = 1'b0;
        end
        tick(); tick();
        chk("R10 capture ignored outside capture mode", irq_seen, 0);

        // R11: ratio change cancels a partial tally
        capture_mode = 1'b1; ps_sel = 4'd1;
        disable_cycle();
        enable = 1'b1;
        tick(); capture_evt = 1'b1;
        tick(); capture_evt = 1'b0;
        tick(); ps_sel = 4'd2;
        tick(); ps_sel = 4'd1;
        tick(); tick();
        tick(); capture_evt = 1'b1;
        tick(); capture_evt = 1'b0;
        tick(); tick();
        chk("R11 tally cleared by ratio change", irq_seen, 0);
        tick(); capture_evt = 1'b1;
        tick(); capture_evt = 1'b0;
        tick(); tick();
        chk("R11 irq after fresh tally", irq_seen, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule